// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This controller produces the system reset from three sources: a supply-good comparator result, a software watchdog, and an external reset request. Whenever any source is active, an internal hold timer is reloaded. The active-low reset output stays low until that timer has counted out a fixed number of ticks after the last source went away. All timing is counted in ticks of a clock-enable input, so a slow tick sets the real-time intervals without a separate clock.

Software keeps the watchdog alive by producing falling edges on a strobe line. If no falling edge arrives within the watchdog period, the controller issues a reset pulse of the hold length. It then restarts the watchdog from zero, so a stalled system sees a repeating train of pulses. A disable input turns off only the watchdog. The block also provides a power-fail flag that follows the supply indication, and a chip-enable output that passes the request through only while the supply is good.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst` is high, `rst_n_o` is 0. After `rst` falls with the supply good, `rst_n_o` stays 0 until the HOLD_TICKS-th tick edge after the last edge with `rst` high, and goes to 1 on that edge.
- R2: When `supply_ok` is 0, `rst_n_o` is 0 in the same cycle, with no register in the path.
- R3: After `supply_ok` returns to 1, `rst_n_o` stays 0 and goes to 1 on the HOLD_TICKS-th tick edge counted from the last edge at which `supply_ok` was 0.
- R4: `pwr_fail_n` is 0 exactly when `supply_ok` is 0.
- R5: `ce_out_n` is 0 only when `ce_req_n` is 0 and `supply_ok` is 1. Otherwise it is 1.
- R6: `strobe_n` passes through two synchronizer flops. A 1-to-0 change sampled at clock edge a restarts the watchdog count at edge a+2. Holding `strobe_n` low gives only one restart.
- R7: With `wd_en` = 1 and `rst_n_o` = 1, the watchdog fires on the WD_TICKS-th tick edge after its last restart if no restart occurs in between. `rst_n_o` then goes to 0 from that edge for HOLD_TICKS tick edges.
- R8: The watchdog count is held at zero while `rst_n_o` is 0 and restarts from zero at release. With no strobes, `rst_n_o` therefore repeats WD_TICKS edges high and HOLD_TICKS edges low.
- R9: With `wd_en` = 0, no watchdog pulse occurs. Supply monitoring, external reset and chip-enable gating keep working.
- R10: `ext_rst_n` passes through two synchronizer flops. A 0 sampled at edge a drives `rst_n_o` to 0 from edge a+2. Release follows the R3 hold, counted from the last edge at which the synchronized request was seen.
- R11: The hold and watchdog counters advance only on edges where `tick` is 1. With `tick` at 0, both intervals are frozen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| tick | input | 1 | Time-base enable; counters step only when 1 |
| supply_ok | input | 1 | Synchronized supply comparator, 1 = within tolerance |
| strobe_n | input | 1 | Watchdog strobe line, falling edge restarts the watchdog |
| wd_en | input | 1 | 1 = watchdog active, 0 = watchdog pulses suppressed |
| ext_rst_n | input | 1 | External reset request, active low |
| ce_req_n | input | 1 | Chip-enable request, active low |
| rst_n_o | output | 1 | System reset, active low |
| pwr_fail_n | output | 1 | Power-fail flag, active low |
| ce_out_n | output | 1 | Gated chip-enable, active low |

## Verification
A hold counter that reloads or decrements wrongly shows up as a reset release one or more ticks off. This appears on `rst_n_o` at the end of every reset interval, so each test that waits for a release exposes it. A watchdog count that is not cleared during reset, or that is cleared by a strobe level rather than an edge, moves the next pulse earlier or later. The error becomes visible at most one watchdog period after the release or strobe. Each cycle compares `rst_n_o`, `pwr_fail_n` and `ce_out_n` against an independently scheduled expectation, so a one-cycle shift in a synchronizer or edge detector is caught on the first edge where it matters.

// File: rtl/rst_supervisor_pkg.sv
`timescale 1ns/1ps
package rst_supervisor_pkg;

    // Conditions that force the reset output and reload the hold timer
    typedef struct packed {
        logic supply_low;
        logic ext_req;
        logic wd_expire;
    } rst_cause_t;

    function automatic logic any_cause(rst_cause_t c);
        return c.supply_low | c.ext_req | c.wd_expire;
    endfunction

    // Counter width able to hold the value n
    function automatic int cnt_width(int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rst_supervisor_sync.sv
`timescale 1ns/1ps
module rst_supervisor_sync #(
    parameter int              WIDTH  = 2,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE  = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= {STAGES{IDLE}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rst_supervisor_hold.sv
`timescale 1ns/1ps
module rst_supervisor_hold
    import rst_supervisor_pkg::*;
#(
    parameter int HOLD_TICKS = 500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  rst_cause_t cause,
    output logic       busy
);
    localparam int CW = cnt_width(HOLD_TICKS);
    localparam logic [CW-1:0] FULL = CW'(HOLD_TICKS);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= FULL;
        end else if (any_cause(cause)) begin
            remain <= FULL;
        end else if (tick && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

    // R11
    release_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(tick));
endmodule

// File: rtl/rst_supervisor_wdog.sv
`timescale 1ns/1ps
module rst_supervisor_wdog
    import rst_supervisor_pkg::*;
#(
    parameter int WD_TICKS = 700
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             tick,
    input  logic                             en,
    input  logic                             held,
    input  logic                             strobe_s,
    output logic                             expire,
    output logic [cnt_width(WD_TICKS)-1:0]   count
);
    localparam int CW = cnt_width(WD_TICKS);
    localparam logic [CW-1:0] LAST = CW'(WD_TICKS - 1);

    logic strobe_q;
    logic strobe_fall;
    logic at_last;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b1;
        else     strobe_q <= strobe_s;
    end

    assign strobe_fall = strobe_q & ~strobe_s;
    assign at_last     = (count == LAST);
    assign expire      = tick & en & ~held & ~strobe_fall & at_last;

    always_ff @(posedge clk) begin
        if (rst || held || !en || strobe_fall) begin
            count <= '0;
        end else if (tick) begin
            count <= at_last ? '0 : count + 1'b1;
        end
    end

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= LAST);
endmodule

// File: rtl/rst_supervisor.sv
`timescale 1ns/1ps
module rst_supervisor
    import rst_supervisor_pkg::*;
#(
    parameter int HOLD_TICKS  = 500,
    parameter int WD_TICKS    = 700,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic supply_ok,
    input  logic strobe_n,
    input  logic wd_en,
    input  logic ext_rst_n,
    input  logic ce_req_n,
    output logic rst_n_o,
    output logic pwr_fail_n,
    output logic ce_out_n
);
    localparam int WCW = cnt_width(WD_TICKS);

    logic [1:0]     line_s;
    logic           strobe_s;
    logic           ext_req_s;
    logic           busy;
    logic           wd_expire;
    logic [WCW-1:0] wd_count;
    rst_cause_t     cause;

    rst_supervisor_sync #(
        .WIDTH (2),
        .STAGES(SYNC_STAGES),
        .IDLE  (2'b11)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({ext_rst_n, strobe_n}),
        .q  (line_s)
    );

    assign strobe_s  = line_s[0];
    assign ext_req_s = ~line_s[1];

    assign cause = '{supply_low: ~supply_ok, ext_req: ext_req_s, wd_expire: wd_expire};

    rst_supervisor_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .cause(cause),
        .busy (busy)
    );

    rst_supervisor_wdog #(.WD_TICKS(WD_TICKS)) u_wdog (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .en      (wd_en),
        .held    (~rst_n_o),
        .strobe_s(strobe_s),
        .expire  (wd_expire),
        .count   (wd_count)
    );

    assign rst_n_o    = supply_ok & ~busy;
    assign pwr_fail_n = supply_ok;
    assign ce_out_n   = ce_req_n | ~supply_ok;

    // R2
    supply_low_rst_chk: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |-> !rst_n_o);

    // R5
    ce_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !ce_out_n |-> (!ce_req_n && supply_ok));

    // R7
    wd_fire_rst_chk: assert property (@(posedge clk) disable iff (rst)
        wd_expire |=> !rst_n_o);

    // R8
    wd_held_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !rst_n_o |=> (wd_count == '0));

    // R10
    ext_req_rst_chk: assert property (@(posedge clk) disable iff (rst)
        ext_req_s |=> !rst_n_o);
endmodule

// File: tb/rst_supervisor_bench.sv
`timescale 1ns/1ps
module rst_supervisor_bench;
    localparam int HOLD = 8;
    localparam int WD   = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic supply_ok = 1'b1;
    logic strobe_n = 1'b1;
    logic wd_en = 1'b1;
    logic ext_rst_n = 1'b1;
    logic ce_req_n = 1'b1;
    logic rst_n_o, pwr_fail_n, ce_out_n;

    always #2.5 clk = ~clk;

    rst_supervisor #(.HOLD_TICKS(HOLD), .WD_TICKS(WD)) u_rst_supervisor (
        .clk(clk), .rst(rst), .tick(tick), .supply_ok(supply_ok),
        .strobe_n(strobe_n), .wd_en(wd_en), .ext_rst_n(ext_rst_n),
        .ce_req_n(ce_req_n), .rst_n_o(rst_n_o), .pwr_fail_n(pwr_fail_n),
        .ce_out_n(ce_out_n)
    );

    typedef struct {
        bit    rst_n;
        bit    pf_n;
        bit    ce_n;
        string tag;
    } exp_t;

    exp_t q[$];
    int   e = 0;        // edge number the current inputs will meet
    int   wd_base = 0;  // edge at which the watchdog count restarts
    int   n_run = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    // Push the expectation for the sample after the coming edge, then wait
    task automatic step(bit r, string tag);
        exp_t it;
        it.rst_n = r;
        it.pf_n  = supply_ok;
        it.ce_n  = ce_req_n | !supply_ok;
        it.tag   = tag;
        q.push_back(it);
        e++;
        @(negedge clk);
    endtask

    task automatic run(int n, bit r, string tag);
        for (int i = 0; i < n; i++) step(r, tag);
    endtask

    // Monitor: pop one expected item per edge and compare
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                n_run++;
                if (rst_n_o !== it.rst_n || pwr_fail_n !== it.pf_n || ce_out_n !== it.ce_n) begin
                    n_fail++;
                    $display("FAIL %s: rst_n/pf_n/ce_n = %0b%0b%0b expected %0b%0b%0b",
                             it.tag, rst_n_o, pwr_fail_n, ce_out_n,
                             it.rst_n, it.pf_n, it.ce_n);
                end
            end
        end
    end

    // Driver
    initial begin
        @(negedge clk);
        run(3, 1'b0, "R1");
        rst = 1'b0;
        run(HOLD - 1, 1'b0, "R1");
        step(1'b1, "R1");

        // strobes keep the system alive
        for (int k = 0; k < 4; k++) begin
            run(5, 1'b1, "R6");
            strobe_n = 1'b0;
            wd_base = e + 2;
            step(1'b1, "R6");
            strobe_n = 1'b1;
            step(1'b1, "R6");
        end

        // strobes stop: first pulse, then a repeat
        while (e < wd_base + WD) step(1'b1, "R7");
        run(HOLD, 1'b0, "R7");
        step(1'b1, "R7");
        run(WD - 1, 1'b1, "R8");
        run(HOLD, 1'b0, "R8");
        step(1'b1, "R8");

        // strobe held low restarts once only
        strobe_n = 1'b0;
        wd_base = e + 2;
        while (e < wd_base + WD) step(1'b1, "R6");
        run(HOLD, 1'b0, "R6");
        strobe_n = 1'b1;
        step(1'b1, "R6");

        // watchdog disabled
        wd_en = 1'b0;
        run(3 * WD, 1'b1, "R9");
        ce_req_n = 1'b0;
        step(1'b1, "R5");
        supply_ok = 1'b0;
        run(3, 1'b0, "R2 R4 R5 R9");
        supply_ok = 1'b1;
        run(HOLD - 1, 1'b0, "R3");
        step(1'b1, "R3");
        ce_req_n = 1'b1;
        step(1'b1, "R5");

        // re-enable, then external request
        wd_en = 1'b1;
        ext_rst_n = 1'b0;
        step(1'b1, "R10");
        step(1'b1, "R10");
        step(1'b0, "R10");
        ext_rst_n = 1'b1;
        run(HOLD + 1, 1'b0, "R10");
        step(1'b1, "R10");

        // tick gating freezes the hold interval
        supply_ok = 1'b0;
        step(1'b0, "R2");
        supply_ok = 1'b1;
        tick = 1'b0;
        run(20, 1'b0, "R11");
        tick = 1'b1;
        run(HOLD - 1, 1'b0, "R11");
        step(1'b1, "R11");
        run(3, 1'b1, "R11");

        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Hang guard
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule